// File: doc/BRIEF.md
# Interleaved Phase Slot Timing Cell

The cell is one slot in a ring of interleaved converter phases. All slots share one system clock. A single phase token travels around the ring: it enters each slot on `phs_i` and leaves on `phs_o`. In the active state the slot delays the token by one clock period through a register. The slot reports when it holds the token, so the local PWM logic can start its cycle on the falling clock edge of that period.

A low-power request, active low, can take the slot out of the ring. The request is first synchronised. It must then stay asserted across a fixed number of token arrivals. After that, on a falling clock edge, the slot switches its delay register to a straight pass-through, tri-states its drivers and detaches from the shared current bus. When the request is released, the slot leaves this state on a falling edge and holds its PWM start off for one more clock.

A separate debug input isolates the phase without changing the token timing.

Top module: `phase_slot_cell`

## Requirements
- R1: While `rst_ni` is low, and after it rises, `phs_o`, `slot_o`, `tri_o`, `iso_o` are 0. The slot starts in the active state.
- R2: In the active state, `phs_o` equals the value `phs_i` had at the previous rising clock edge.
- R3: In the active state, `slot_o` is 1 exactly while the delayed token (`phs_o`) is 1.
- R4: `lp_ni` low is the low-power request. It passes through `SYNC_STAGES` (default 2) rising-edge synchroniser flops. Once synchronised, a token arrival is counted at each rising edge where `phs_i` is 1 and `phs_o` is 0. `tri_o` stays 0 through the first `QUAL_TOKENS`-1 (default 7) arrivals. It rises on the falling clock edge after the `QUAL_TOKENS`-th arrival.
- R5: If the synchronised request drops before the count completes, the count returns to zero. A later request needs a full `QUAL_TOKENS` new arrivals.
- R6: While in the low-power state:
  - `phs_o` follows `phs_i` combinationally;
  - `tri_o` and `iso_o` are 1;
  - `slot_o` is 0.
- R7: After `lp_ni` rises, `tri_o` clears on the falling edge after the third rising edge. This is two synchroniser edges plus one qualifier edge. `slot_o` stays 0 until the next rising edge after that.
- R8: While `dbg_i` is 1:
  - `drv_low_o` and `iso_o` are 1;
  - `tri_o` is unaffected;
  - the `phs_i` to `phs_o` timing of R2 is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phs_i | input | 1 | Phase token from the previous slot |
| lp_ni | input | 1 | Low-power request, active low, asynchronous |
| dbg_i | input | 1 | Debug isolate request |
| phs_o | output | 1 | Phase token to the next slot |
| slot_o | output | 1 | This slot holds the token; PWM may set on the falling edge |
| tri_o | output | 1 | Drivers tri-state request |
| iso_o | output | 1 | Current-bus disconnect request |
| drv_low_o | output | 1 | Both drivers pulled low |

## Verification
The bench builds the cell with the default parameters:
- two synchroniser stages;
- a qualification count of eight tokens.

With these defaults, the seven-versus-eight token boundary is directly observable, as is the exact falling-edge cycle of entry and exit.

A four-clock token period lets the bench check the registered and bypassed token paths against each other. An aborted request followed by a fresh one exercises the count restart. Holding the token across the release shows the extra clock of PWM hold-off.

// File: rtl/phase_slot_pkg.sv
package phase_slot_pkg;
  localparam int unsigned DEF_QUAL_TOKENS = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic tri_req;
    logic iso_req;
    logic drv_low;
  } slot_ctrl_t;
endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= d_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lp_qualifier.sv
module lp_qualifier #(
  parameter int unsigned QUAL_TOKENS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic tok_rise_i,
  output logic armed_o
);
  localparam int unsigned CW = $clog2(QUAL_TOKENS + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_TOKENS - 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!req_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!armed_q && tok_rise_i) begin
      if (cnt_q == LAST) armed_q <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/fall_align.sv
module fall_align (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  output logic flag_o,
  output logic hold_o
);
  logic flag_q, hold_q;

  // flag changes only on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else flag_q <= armed_i;
  end

  // one-clock echo keeps the PWM start off after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else hold_q <= flag_q;
  end

  assign flag_o = flag_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/phase_slot_cell.sv
module phase_slot_cell
  import phase_slot_pkg::*;
#(
  parameter int unsigned QUAL_TOKENS = DEF_QUAL_TOKENS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phs_i,
  input  logic lp_ni,
  input  logic dbg_i,
  output logic phs_o,
  output logic slot_o,
  output logic tri_o,
  output logic iso_o,
  output logic drv_low_o
);
  logic       phs_d_q;
  logic       req_s;
  logic       armed;
  logic       lp_flag, lp_hold;
  slot_ctrl_t ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phs_d_q <= 1'b0;
    else phs_d_q <= phs_i;
  end

  lp_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (~lp_ni),
    .q_o   (req_s)
  );

  lp_qualifier #(.QUAL_TOKENS(QUAL_TOKENS)) i_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_s),
    .tok_rise_i(phs_i & ~phs_d_q),
    .armed_o   (armed)
  );

  fall_align i_align (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .armed_i(armed),
    .flag_o (lp_flag),
    .hold_o (lp_hold)
  );

  always_comb begin
    ctrl.tri_req = lp_flag;
    ctrl.iso_req = lp_flag | dbg_i;
    ctrl.drv_low = dbg_i;
  end

  assign phs_o     = lp_flag ? phs_i : phs_d_q;
  assign slot_o    = phs_d_q & ~lp_flag & ~lp_hold;
  assign tri_o     = ctrl.tri_req;
  assign iso_o     = ctrl.iso_req;
  assign drv_low_o = ctrl.drv_low;
endmodule

// File: rtl/phase_slot_checker.sv
module phase_slot_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic phs_i,
  input logic lp_ni,
  input logic dbg_i,
  input logic phs_o,
  input logic slot_o,
  input logic tri_o,
  input logic iso_o,
  input logic drv_low_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else past_ok <= 1'b1;
  end

  a_r2_token_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !tri_o) |-> (phs_o == $past(phs_i)));

  a_r6_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_o |-> (phs_o == phs_i && iso_o && !slot_o));

  a_r4_entry_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $rose(tri_o)) |-> !$past(lp_ni, 3));

  a_r8_debug: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_i |-> (drv_low_o && iso_o));

  a_r3_slot_token: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o |-> (phs_o && !tri_o));
endmodule

bind phase_slot_cell phase_slot_checker i_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .phs_i    (phs_i),
  .lp_ni    (lp_ni),
  .dbg_i    (dbg_i),
  .phs_o    (phs_o),
  .slot_o   (slot_o),
  .tri_o    (tri_o),
  .iso_o    (iso_o),
  .drv_low_o(drv_low_o)
);

// File: tb/test_phase_slot_cell.sv
`timescale 1ns/100ps
module test_phase_slot_cell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phs_i = 1'b0, lp_n = 1'b1, dbg = 1'b0;
  logic phs_o, slot_o, tri_o, iso_o, drv_low_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  phase_slot_cell i_phase_slot_cell (
    .clk_i(clk), .rst_ni(rst_n), .phs_i(phs_i), .lp_ni(lp_n), .dbg_i(dbg),
    .phs_o(phs_o), .slot_o(slot_o), .tri_o(tri_o), .iso_o(iso_o),
    .drv_low_o(drv_low_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // tasks start and end 1 ns after a rising edge
  task automatic send_token();
    phs_i = 1'b1;
    @(posedge clk); #1 phs_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #2;
    check("R1 phs_o in reset", phs_o, 1'b0);
    check("R1 tri_o in reset", tri_o, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 slot_o after reset", slot_o, 1'b0);
    check("R1 iso_o after reset", iso_o, 1'b0);
  endtask

  task automatic t_normal_delay();
    phs_i = 1'b1;
    #3 check("R2 phs_o before edge", phs_o, 1'b0);
    check("R3 slot_o before token", slot_o, 1'b0);
    @(posedge clk); #3;
    check("R2 phs_o one clock later", phs_o, 1'b1);
    check("R3 slot_o while token held", slot_o, 1'b1);
    @(posedge clk); #1 phs_i = 1'b0;
    @(posedge clk); #3;
    check("R2 phs_o falls one clock later", phs_o, 1'b0);
    check("R3 slot_o after token", slot_o, 1'b0);
    @(posedge clk); #1;
  endtask

  task automatic t_qualify();
    lp_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    for (int k = 0; k < 7; k++) send_token();
    check("R4 tri_o after 7 tokens", tri_o, 1'b0);
    phs_i = 1'b1;
    @(posedge clk); #1;
    check("R4 tri_o before falling edge", tri_o, 1'b0);
    #2;
    check("R4 tri_o after 8th token", tri_o, 1'b1);
    check("R6 iso_o in low power", iso_o, 1'b1);
    @(posedge clk); #1 phs_i = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic t_bypass();
    phs_i = 1'b1;
    #1 check("R6 phs_o follows high", phs_o, 1'b1);
    check("R6 slot_o off", slot_o, 1'b0);
    phs_i = 1'b0;
    #1 check("R6 phs_o follows low", phs_o, 1'b0);
    @(posedge clk); #1;
  endtask

  task automatic t_release();
    phs_i = 1'b1;
    @(posedge clk); #1 lp_n = 1'b1;
    @(posedge clk);
    @(posedge clk); #3;
    check("R7 tri_o still set", tri_o, 1'b1);
    @(posedge clk); #3;
    check("R7 tri_o cleared", tri_o, 1'b0);
    check("R7 slot_o held off", slot_o, 1'b0);
    @(posedge clk); #3;
    check("R7 slot_o restored", slot_o, 1'b1);
    @(posedge clk); #1 phs_i = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic t_restart();
    lp_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    for (int k = 0; k < 5; k++) send_token();
    lp_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 lp_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    for (int k = 0; k < 7; k++) send_token();
    check("R5 no entry after restart and 7 tokens", tri_o, 1'b0);
    send_token();
    check("R5 entry after fresh 8 tokens", tri_o, 1'b1);
    lp_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    check("R5 exit after release", tri_o, 1'b0);
  endtask

  task automatic t_debug();
    dbg = 1'b1;
    #1 check("R8 drv_low_o", drv_low_o, 1'b1);
    check("R8 iso_o", iso_o, 1'b1);
    check("R8 tri_o unaffected", tri_o, 1'b0);
    phs_i = 1'b1;
    #1 check("R8 phs_o still registered", phs_o, 1'b0);
    @(posedge clk); #3;
    check("R8 phs_o one clock later", phs_o, 1'b1);
    @(posedge clk); #1 phs_i = 1'b0; dbg = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    t_reset();
    t_normal_delay();
    t_qualify();
    t_bypass();
    t_release();
    t_restart();
    t_debug();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule